// File: doc/BRIEF.md
# External Reset Pin Manager

This block belongs to a reset controller that runs entirely on the slow clock. It watches an active-low, open-drain reset pad that can be pulled low from outside the chip. The pad level passes through a synchronizer. A low level that the block did not cause itself counts as a user reset request. A small mode register chooses how that request is handled. It can start a full chip reset, it can raise the controller interrupt instead, or it can be ignored. In every case a sticky status flag records that the pad was pulled low, and software clears that flag by reading the status.

The same pad is also an output. When the reset sequencing logic asks for a reset, or when an accepted user request starts one, the block pulls the pad low for a programmable number of slow-clock cycles. It holds the processor reset and the peripheral reset low for the same window. A peripheral-only request leaves the processor running. The block's own drive also brings the pad low, and that low is masked so that it does not come back as a new user request.

All ports are plain level or strobe signals. Nothing in this block moves a stream of data, so there is no valid/ready handshake and nothing applies back-pressure.

Top module: `ext_reset_pin_mgr`

## Requirements
- R1: `stat_level` equals the pad level after two slow-clock edges, and it resets to 1.
- R2: `stat_event` becomes 1 on the edge after the synchronized pad level is low while the block is not masking its own drive. It then stays 1 until a status read.
- R3: A one-cycle `stat_rd` pulse clears `stat_event`. If a read and a new set condition happen on the same edge, the flag stays 1.
- R4: When usr_en=1 and irq_en=0, the first cycle of an accepted low level gives a one-cycle `usr_rst_evt` pulse. On the next edge a full reset starts: the pad is driven, and both reset outputs go low.
- R5: When irq_en=1, an accepted low level starts no reset and gives no `usr_rst_evt`. `irq` is 1 while both `stat_event` and irq_en are 1.
- R6: When usr_en=0 and irq_en=0, an accepted low level only updates the status bits. There is no drive, no reset, no event and no interrupt.
- R7: A `rst_req` pulse drives `pin_drive_low` and holds both resets low for exactly 2^(len+1) cycles, starting the cycle after the request edge.
- R8: A `rst_req_periph` pulse drives the pad and holds `periph_rst_n` low for 2^(len+1) cycles. `proc_rst_n` stays 1.
- R9: A low level caused by the block's own drive does not set `stat_event` and does not count as a user request. This masking lasts until the synchronized level has been seen high after the drive ends.
- R10: A `mode_we` pulse loads usr_en, irq_en and len. Their reset values are usr_en=1, irq_en=0 and len=0, which gives a 2-cycle pulse.
- R11: A request that arrives while a pulse is running reloads the full length. The drive therefore lasts for the elapsed cycles plus 2^(len+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Sampled level of the reset pad |
| pin_drive_low | output | 1 | 1 = pull the pad low (open-drain enable) |
| mode_we | input | 1 | Mode register write strobe |
| mode_usr_en | input | 1 | Write data: a pad low may request a reset |
| mode_irq_en | input | 1 | Write data: a pad low raises the interrupt instead |
| mode_len | input | 4 | Write data: pulse length code, 2^(len+1) cycles |
| stat_rd | input | 1 | Status read strobe; clears the sticky flag |
| stat_level | output | 1 | Synchronized pad level |
| stat_event | output | 1 | Sticky "pad was pulled low" flag |
| rst_req | input | 1 | Full reset request from the sequencer |
| rst_req_periph | input | 1 | Peripheral-only reset request |
| usr_rst_evt | output | 1 | One-cycle pulse: user reset accepted |
| irq | output | 1 | Controller interrupt |
| proc_rst_n | output | 1 | Processor and watchdog reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |

## Verification
An external low of the pad is applied under six mode settings. These cover reset routing at three pulse lengths, interrupt routing with and without usr_en, and the silent setting. The counts of driven cycles, reset-low cycles and event pulses separate the three routings, and they also expose a low that triggers again after the block's own drive. Requests from the sequencer separate the full reset from the peripheral-only reset. In those same runs, a clear sticky flag shows that the block's own drive was masked. A request inside a running pulse shows that the count reloads and does not carry on from where it was. A read issued on the edge where the flag first sets tells apart the two possible priorities of set and clear.

// File: rtl/erpm_pkg.sv
package erpm_pkg;
  localparam int LEN_W = 4;

  typedef struct packed {
    logic             usr_en;
    logic             irq_en;
    logic [LEN_W-1:0] len;
  } mode_t;

  localparam mode_t MODE_RST = '{usr_en: 1'b1, irq_en: 1'b0, len: '0};
endpackage

// File: rtl/erpm_sync.sv
module erpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/erpm_pulse_timer.sv
module erpm_pulse_timer #(
  parameter int LEN_W = 4,
  parameter int CNT_W = (1 << LEN_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_proc,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             proc_hold
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic [LEN_W:0]   shamt;

  assign shamt    = {1'b0, len} + 1'b1;
  assign load_val = {{(CNT_W-1){1'b0}}, 1'b1} << shamt;
  assign active   = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      proc_hold <= 1'b0;
    end else if (start) begin
      cnt       <= load_val;
      proc_hold <= start_proc | (active & proc_hold);
    end else if (active) begin
      cnt       <= cnt - 1'b1;
      proc_hold <= (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) ? 1'b0 : proc_hold;
    end
  end

  // R7
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (cnt == $past(cnt) - 1'b1));

  // R8
  proc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_hold) |-> $past(start_proc));
endmodule

// File: rtl/erpm_pin_event.sv
module erpm_pin_event (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic drive,
  input  logic rd,
  output logic sticky,
  output logic low_edge
);
  logic mask;
  logic seen_prev;
  logic seen_low;

  assign seen_low = !level && !mask && !drive;
  assign low_edge = seen_low && !seen_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= 1'b0;
      seen_prev <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      if (drive)      mask <= 1'b1;
      else if (level) mask <= 1'b0;
      seen_prev <= seen_low;
      if (seen_low)   sticky <= 1'b1;
      else if (rd)    sticky <= 1'b0;
    end
  end

  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_low |=> sticky);

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive) |-> mask);
endmodule

// File: rtl/ext_reset_pin_mgr.sv
module ext_reset_pin_mgr
  import erpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  output logic             pin_drive_low,
  input  logic             mode_we,
  input  logic             mode_usr_en,
  input  logic             mode_irq_en,
  input  logic [LEN_W-1:0] mode_len,
  input  logic             stat_rd,
  output logic             stat_level,
  output logic             stat_event,
  input  logic             rst_req,
  input  logic             rst_req_periph,
  output logic             usr_rst_evt,
  output logic             irq,
  output logic             proc_rst_n,
  output logic             periph_rst_n
);
  localparam int CNT_W = (1 << LEN_W) + 1;

  mode_t mode_q;
  logic  level;
  logic  low_edge;
  logic  usr_trig;
  logic  start;
  logic  active;
  logic  proc_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_we) mode_q <= '{usr_en: mode_usr_en, irq_en: mode_irq_en, len: mode_len};

  erpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level)
  );

  erpm_pin_event u_event (
    .clk(clk), .rst_n(rst_n), .level(level), .drive(active),
    .rd(stat_rd), .sticky(stat_event), .low_edge(low_edge)
  );

  assign usr_trig = low_edge && mode_q.usr_en && !mode_q.irq_en;
  assign start    = rst_req || rst_req_periph || usr_trig;

  erpm_pulse_timer #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_proc(rst_req || usr_trig), .len(mode_q.len),
    .active(active), .proc_hold(proc_hold)
  );

  assign pin_drive_low = active;
  assign stat_level    = level;
  assign usr_rst_evt   = usr_trig;
  assign irq           = stat_event && mode_q.irq_en;
  assign periph_rst_n  = !active;
  assign proc_rst_n    = !(active && proc_hold);

  // R5
  irq_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_edge && mode_q.irq_en && !rst_req && !rst_req_periph && !active) |=> !pin_drive_low);
endmodule

// File: tb/ext_reset_pin_mgr_bench.sv
module ext_reset_pin_mgr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_drive_low;
  logic mode_we = 1'b0, mode_usr_en = 1'b0, mode_irq_en = 1'b0;
  logic [3:0] mode_len = 4'd0;
  logic stat_rd = 1'b0, rst_req = 1'b0, rst_req_periph = 1'b0;
  logic stat_level, stat_event, usr_rst_evt, irq, proc_rst_n, periph_rst_n;

  int checks = 0, errors = 0;
  int n_drv, n_proc, n_per, n_evt;
  bit counting = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign pin_in = ~(ext_low | pin_drive_low);

  ext_reset_pin_mgr u_ext_reset_pin_mgr (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
    .mode_we(mode_we), .mode_usr_en(mode_usr_en), .mode_irq_en(mode_irq_en),
    .mode_len(mode_len), .stat_rd(stat_rd), .stat_level(stat_level),
    .stat_event(stat_event), .rst_req(rst_req), .rst_req_periph(rst_req_periph),
    .usr_rst_evt(usr_rst_evt), .irq(irq), .proc_rst_n(proc_rst_n),
    .periph_rst_n(periph_rst_n)
  );

  always @(negedge clk) if (counting) begin
    if (pin_drive_low) n_drv++;
    if (!proc_rst_n)   n_proc++;
    if (!periph_rst_n) n_per++;
    if (usr_rst_evt)   n_evt++;
  end

  // vector fields: {usr_en, irq_en, len[3:0]}
  localparam logic [5:0] VEC [6] = '{6'b10_0000, 6'b10_0011, 6'b10_0101,
                                     6'b01_0010, 6'b11_0001, 6'b00_0100};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(bit u, bit i, logic [3:0] l);
    @(negedge clk);
    mode_we = 1'b1; mode_usr_en = u; mode_irq_en = i; mode_len = l;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic cnt_clear();
    n_drv = 0; n_proc = 0; n_per = 0; n_evt = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state: R1 R2 R10
    chk("R1 level after reset", stat_level, 1);
    chk("R2 sticky after reset", stat_event, 0);
    chk("R10 no drive after reset", pin_drive_low, 0);
    chk("R10 proc after reset", proc_rst_n, 1);
    chk("R10 periph after reset", periph_rst_n, 1);
    chk("R5 irq after reset", irq, 0);

    // latency with reset-value mode: R1 R4 R10
    ext_low = 1'b1;
    cyc(1);
    chk("R1 level one edge", stat_level, 1);
    chk("R4 proc early", proc_rst_n, 1);
    cyc(1);
    chk("R1 level two edges", stat_level, 0);
    chk("R4 event pulse", usr_rst_evt, 1);
    chk("R4 proc before start", proc_rst_n, 1);
    cyc(1);
    chk("R4 proc low", proc_rst_n, 0);
    chk("R4 pad driven", pin_drive_low, 1);
    chk("R2 sticky set", stat_event, 1);
    chk("R4 event one cycle", usr_rst_evt, 0);
    ext_low = 1'b0;
    cyc(1);
    chk("R10 default len second cycle", proc_rst_n, 0);
    cyc(1);
    chk("R10 default len ends", proc_rst_n, 1);
    chk("R10 drive ends", pin_drive_low, 0);
    cyc(6);
    rd_status();
    chk("R3 read clears", stat_event, 0);

    // vector table: R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      automatic bit u = VEC[v][5];
      automatic bit i = VEC[v][4];
      automatic logic [3:0] l = VEC[v][3:0];
      automatic bit trig = u && !i;
      automatic int n_exp = trig ? (1 << (l + 1)) : 0;
      wr_mode(u, i, l);
      cnt_clear();
      counting = 1'b1;
      ext_low = 1'b1;
      cyc(6);
      ext_low = 1'b0;
      cyc(150);
      counting = 1'b0;
      chk(trig ? "R4 drive cycles" : (i ? "R5 no drive" : "R6 no drive"), n_drv, n_exp);
      chk(trig ? "R4 proc cycles" : (i ? "R5 no proc reset" : "R6 no proc reset"), n_proc, n_exp);
      chk(trig ? "R4 periph cycles" : "R6 no periph reset", n_per, n_exp);
      chk(trig ? "R9 single event" : "R5 R6 no event", n_evt, trig ? 1 : 0);
      chk(i ? "R5 irq raised" : "R6 no irq", irq, i ? 1 : 0);
      chk("R2 sticky held", stat_event, 1);
      chk("R1 level back high", stat_level, 1);
      rd_status();
      chk("R3 sticky cleared", stat_event, 0);
      chk("R5 irq cleared", irq, 0);
    end

    // full request and self-drive masking: R7 R9
    wr_mode(1'b1, 1'b0, 4'd2);
    cnt_clear();
    counting = 1'b1;
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    cyc(30);
    counting = 1'b0;
    chk("R7 drive cycles", n_drv, 8);
    chk("R7 proc cycles", n_proc, 8);
    chk("R7 periph cycles", n_per, 8);
    chk("R9 no event from own drive", n_evt, 0);
    chk("R9 sticky clear after own drive", stat_event, 0);

    // peripheral-only request: R8
    cnt_clear();
    counting = 1'b1;
    @(negedge clk); rst_req_periph = 1'b1;
    @(negedge clk); rst_req_periph = 1'b0;
    cyc(30);
    counting = 1'b0;
    chk("R8 drive cycles", n_drv, 8);
    chk("R8 periph cycles", n_per, 8);
    chk("R8 proc untouched", n_proc, 0);

    // restart during pulse: R11
    cnt_clear();
    counting = 1'b1;
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    cyc(2);
    rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    cyc(30);
    counting = 1'b0;
    chk("R11 reload drive", n_drv, 11);
    chk("R11 reload proc", n_proc, 11);

    // read on the set edge: R3
    wr_mode(1'b0, 1'b0, 4'd0);
    ext_low = 1'b1;
    cyc(2);
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    chk("R3 set wins over read", stat_event, 1);
    chk("R6 silent mode no drive", pin_drive_low, 0);
    ext_low = 1'b0;
    cyc(4);
    rd_status();
    chk("R3 later read clears", stat_event, 0);

    done = 1'b1;
    finish_run();
  end
endmodule